// File: doc/BRIEF.md
# Selectable 3x3 Rank-Order Image Filter

This block processes a whole 200x150 grayscale frame held in a read-only pixel memory and writes the filtered frame into a separate writable memory. After a start pulse, it reads each source pixel once, in raster order, through a synchronous read port. Two row buffers and a 3x3 column shift structure build the neighbourhood around every pixel. A single pipelined sorting network then puts the nine samples in ascending order.

A two-bit mode, captured when the frame starts, selects which sorted position becomes the result. The middle position removes impulse noise (median). The lowest position gives grayscale erosion and the highest gives grayscale dilation. Neighbours that fall outside the frame take the value of the nearest edge pixel, so the output frame has the same size as the input. A one-cycle done pulse follows the last result write.

Top module: `rank_filter3x3`

## Requirements
- R1: After a start, `src_rd_en` is high exactly 30000 times, once for each source address, in increasing order `y*200+x`. The source data for an address is expected on `src_rd_data` in the cycle after `src_rd_en`.
- R2: Exactly 30000 result writes follow each accepted start, one per pixel, in increasing order. The write address is `y*200+x` of the centre pixel, and it is always below 30000.
- R3: With mode `2'b00`, each result is the fifth smallest of the nine neighbourhood samples.
- R4: With mode `2'b01`, each result is the smallest of the nine neighbourhood samples.
- R5: With mode `2'b10`, each result is the largest of the nine neighbourhood samples.
- R6: Mode `2'b11` produces the same results as mode `2'b00`.
- R7: A neighbourhood position outside the frame uses the nearest pixel on the frame edge. Row and column indices are clamped to 0..149 and 0..199.
- R8: The mode is captured in the cycle that `start` is accepted. A start pulse or a mode change while a frame is in progress has no effect on that frame's results.
- R9: `done` is high for exactly one cycle, in the cycle after the write to address 29999. No write occurs in that cycle or after it until the next start.
- R10: After reset, `src_rd_en`, `res_wr_en` and `done` are low and stay low until a start pulse arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begins one frame when the block is idle |
| mode | input | 2 | Rank select: 00 median, 01 minimum, 10 maximum, 11 median |
| src_rd_en | output | 1 | Read strobe for the source frame memory |
| src_rd_addr | output | 15 | Source pixel address, `y*200+x` |
| src_rd_data | input | 8 | Source pixel, valid one cycle after the strobe |
| res_wr_en | output | 1 | Write strobe for the result frame memory |
| res_wr_addr | output | 15 | Result pixel address, `y*200+x` |
| res_wr_data | output | 8 | Filtered pixel value |
| done | output | 1 | One-cycle pulse after the final result write |

## Verification
The assertions assume two things about the surroundings. The source memory answers each read in the next cycle without stalling, and the result memory accepts a write in every cycle, because the block has no back-pressure. The bench models the source memory as a one-cycle registered function of the address, so the data always arrives in the expected cycle. It drives `start` and `mode` only on falling edges. While a frame runs, its only stimulus is a deliberate second start pulse and mode change, which checks that the captured mode is held.

// File: rtl/rank_filter_pkg.sv
// Shared constants and the mode type for the 3x3 rank-order filter.
package rank_filter_pkg;

    localparam int WIN_N   = 9;          // samples in one neighbourhood
    localparam int MED_IDX = WIN_N / 2;  // ascending position of the median

    typedef enum logic [1:0] {
        RANK_MEDIAN = 2'b00,
        RANK_MIN    = 2'b01,
        RANK_MAX    = 2'b10,
        RANK_ALT    = 2'b11
    } rank_sel_e;

endpackage

// File: rtl/rank_scan.sv
// Frame scan sequencer.
// Walks an extended raster of (IMG_H+1) x (IMG_W+1) steps after an accepted
// start. The extra row and column let the window reach the bottom and right
// edges. It reads the source memory only on real pixels, so each address is
// read once. Assumes the source memory answers one cycle after a read.
module rank_scan #(
    parameter int IMG_W = 200,
    parameter int IMG_H = 150,
    localparam int COL_W  = $clog2(IMG_W + 1),
    localparam int ROW_W  = $clog2(IMG_H + 1),
    localparam int ADDR_W = $clog2(IMG_W * IMG_H)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              frame_done,
    output logic              busy,
    output logic              step_valid,
    output logic [ROW_W-1:0]  step_row,
    output logic [COL_W-1:0]  step_col,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr
);

    logic             run_q;
    logic             busy_q;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;

    // Step counters: start a frame when idle, advance one step per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            busy_q <= 1'b0;
            row_q  <= '0;
            col_q  <= '0;
        end else if (start && !busy_q) begin
            run_q  <= 1'b1;
            busy_q <= 1'b1;
            row_q  <= '0;
            col_q  <= '0;
        end else begin
            if (frame_done) begin
                busy_q <= 1'b0;
            end
            if (run_q) begin
                if (col_q == COL_W'(IMG_W)) begin
                    col_q <= '0;
                    if (row_q == ROW_W'(IMG_H)) begin
                        run_q <= 1'b0;
                    end else begin
                        row_q <= row_q + ROW_W'(1);
                    end
                end else begin
                    col_q <= col_q + COL_W'(1);
                end
            end
        end
    end

    // Read only inside the real frame; the padding steps reuse stored pixels.
    assign rd_en      = run_q && (row_q < ROW_W'(IMG_H)) && (col_q < COL_W'(IMG_W));
    assign rd_addr    = ADDR_W'(row_q) * ADDR_W'(IMG_W) + ADDR_W'(col_q);
    assign busy       = busy_q;
    assign step_valid = run_q;
    assign step_row   = row_q;
    assign step_col   = col_q;

endmodule

// File: rtl/rank_window.sv
// 3x3 neighbourhood builder with edge replication.
// Stage 1 aligns with the source data. It forms a vertical triple from two
// row buffers and the incoming pixel, and clamps the top and bottom rows.
// Stage 2 holds three triples and clamps the left column; the right column
// is clamped by repeating the newest triple. Assumes steps arrive in the
// order produced by rank_scan.
module rank_window #(
    parameter int IMG_W = 200,
    parameter int IMG_H = 150,
    parameter int PIX_W = 8,
    localparam int COL_W  = $clog2(IMG_W + 1),
    localparam int ROW_W  = $clog2(IMG_H + 1),
    localparam int ADDR_W = $clog2(IMG_W * IMG_H)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        step_valid,
    input  logic [ROW_W-1:0]            step_row,
    input  logic [COL_W-1:0]            step_col,
    input  logic [PIX_W-1:0]            pix_in,
    output logic                        win_valid,
    output logic [8:0][PIX_W-1:0]       win,
    output logic [ADDR_W-1:0]           win_addr,
    output logic                        win_last
);

    logic [PIX_W-1:0] row_near [IMG_W];   // previous row
    logic [PIX_W-1:0] row_far  [IMG_W];   // row before that

    logic             s1_valid;
    logic [ROW_W-1:0] s1_row;
    logic [COL_W-1:0] s1_col;

    logic             pad_col;
    logic [COL_W-1:0] rd_col;
    logic [PIX_W-1:0] mid_pix, far_pix, top_pix, bot_pix;

    logic [2:0][PIX_W-1:0] col_in, col0, col1, col2;
    logic                  s2_first_col;

    // Stage 1 alignment with the one-cycle source read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
        end else begin
            s1_valid <= step_valid;
        end
        s1_row <= step_row;
        s1_col <= step_col;
    end

    // Vertical triple with top and bottom clamping.
    always_comb begin
        pad_col = (s1_col == COL_W'(IMG_W));
        rd_col  = pad_col ? COL_W'(IMG_W - 1) : s1_col;
        mid_pix = row_near[rd_col];
        far_pix = row_far[rd_col];
        top_pix = (s1_row == ROW_W'(1))     ? mid_pix : far_pix;
        bot_pix = (s1_row == ROW_W'(IMG_H)) ? mid_pix : pix_in;
        col_in  = pad_col ? col0 : {top_pix, mid_pix, bot_pix};
    end

    // Row buffer update: push the old row down, store the new pixel.
    always_ff @(posedge clk) begin
        if (s1_valid && !pad_col && (s1_row < ROW_W'(IMG_H))) begin
            row_far[rd_col]  <= mid_pix;
            row_near[rd_col] <= pix_in;
        end
    end

    // Column shift register of vertical triples.
    always_ff @(posedge clk) begin
        if (s1_valid) begin
            col0 <= col_in;
            col1 <= col0;
            col2 <= col1;
        end
    end

    // Stage 2 control: a window is complete once a row and a column lead exist.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_valid <= 1'b0;
        end else begin
            win_valid <= s1_valid && (s1_row != '0) && (s1_col != '0);
        end
        s2_first_col <= (s1_col == COL_W'(1));
        win_addr     <= ADDR_W'(s1_row - ROW_W'(1)) * ADDR_W'(IMG_W)
                      + ADDR_W'(s1_col - COL_W'(1));
        win_last     <= (s1_row == ROW_W'(IMG_H)) && (s1_col == COL_W'(IMG_W));
    end

    // Left column clamp at the frame's first column.
    assign win = {(s2_first_col ? col1 : col2), col1, col0};

endmodule

// File: rtl/rank_sorter.sv
// Pipelined odd-even transposition sorter.
// N register stages, each a layer of compare-exchange cells that alternates
// between even and odd pairs. Output position 0 holds the smallest value.
// A valid bit and a tag travel alongside the data with the same latency.
module rank_sorter #(
    parameter int PIX_W = 8,
    parameter int N     = 9,
    parameter int TAG_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [N-1:0][PIX_W-1:0] in_vals,
    input  logic [TAG_W-1:0]        in_tag,
    output logic                    out_valid,
    output logic [N-1:0][PIX_W-1:0] out_vals,
    output logic [TAG_W-1:0]        out_tag
);

    for (genvar k = 0; k < N; k++) begin : g_st
        localparam int PH = k % 2;
        logic [N-1:0][PIX_W-1:0] d, nx, q;
        logic                    dv, qv;
        logic [TAG_W-1:0]        dt, qt;

        if (k == 0) begin : g_src
            assign d  = in_vals;
            assign dv = in_valid;
            assign dt = in_tag;
        end else begin : g_src
            assign d  = g_st[k-1].q;
            assign dv = g_st[k-1].qv;
            assign dt = g_st[k-1].qt;
        end

        // One layer of compare-exchange on pairs starting at PH.
        always_comb begin
            nx = d;
            for (int i = PH; i + 1 < N; i += 2) begin
                if (d[i] > d[i+1]) begin
                    nx[i]   = d[i+1];
                    nx[i+1] = d[i];
                end
            end
        end

        // Stage valid register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                qv <= 1'b0;
            end else begin
                qv <= dv;
            end
        end

        // Stage data and tag registers.
        always_ff @(posedge clk) begin
            q  <= nx;
            qt <= dt;
        end
    end

    assign out_valid = g_st[N-1].qv;
    assign out_vals  = g_st[N-1].q;
    assign out_tag   = g_st[N-1].qt;

endmodule

// File: rtl/rank_filter3x3.sv
// Top of the selectable 3x3 rank-order frame filter.
// On start it captures the mode, scans the source frame once, ranks every
// replicated-edge neighbourhood in one shared sorter, and writes one result
// per pixel. A done pulse follows the last write. Assumes the source memory
// answers one cycle after a read and the result memory never stalls.
module rank_filter3x3 #(
    parameter int IMG_W = 200,
    parameter int IMG_H = 150,
    parameter int PIX_W = 8,
    localparam int COL_W  = $clog2(IMG_W + 1),
    localparam int ROW_W  = $clog2(IMG_H + 1),
    localparam int ADDR_W = $clog2(IMG_W * IMG_H),
    localparam int TAG_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode,
    output logic              src_rd_en,
    output logic [ADDR_W-1:0] src_rd_addr,
    input  logic [PIX_W-1:0]  src_rd_data,
    output logic              res_wr_en,
    output logic [ADDR_W-1:0] res_wr_addr,
    output logic [PIX_W-1:0]  res_wr_data,
    output logic              done
);
    import rank_filter_pkg::*;

    rank_sel_e mode_q;
    logic      busy;
    logic      step_valid;
    logic [ROW_W-1:0] step_row;
    logic [COL_W-1:0] step_col;

    logic                        win_valid, win_last;
    logic [WIN_N-1:0][PIX_W-1:0] win;
    logic [ADDR_W-1:0]           win_addr;

    logic                        srt_valid;
    logic [WIN_N-1:0][PIX_W-1:0] srt_vals;
    logic [TAG_W-1:0]            srt_tag;
    logic [PIX_W-1:0]            picked;
    logic                        last_q;

    // Mode capture at an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= RANK_MEDIAN;
        end else if (start && !busy) begin
            mode_q <= rank_sel_e'(mode);
        end
    end

    rank_scan #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .frame_done (done),
        .busy       (busy),
        .step_valid (step_valid),
        .step_row   (step_row),
        .step_col   (step_col),
        .rd_en      (src_rd_en),
        .rd_addr    (src_rd_addr)
    );

    rank_window #(.IMG_W(IMG_W), .IMG_H(IMG_H), .PIX_W(PIX_W)) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_valid (step_valid),
        .step_row   (step_row),
        .step_col   (step_col),
        .pix_in     (src_rd_data),
        .win_valid  (win_valid),
        .win        (win),
        .win_addr   (win_addr),
        .win_last   (win_last)
    );

    rank_sorter #(.PIX_W(PIX_W), .N(WIN_N), .TAG_W(TAG_W)) u_sorter (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (win_valid),
        .in_vals   (win),
        .in_tag    ({win_last, win_addr}),
        .out_valid (srt_valid),
        .out_vals  (srt_vals),
        .out_tag   (srt_tag)
    );

    // Rank selection by the captured mode.
    always_comb begin
        case (mode_q)
            RANK_MIN: picked = srt_vals[0];
            RANK_MAX: picked = srt_vals[WIN_N-1];
            default:  picked = srt_vals[MED_IDX];
        endcase
    end

    // Result write port and end-of-frame pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_wr_en   <= 1'b0;
            res_wr_addr <= '0;
            res_wr_data <= '0;
            last_q      <= 1'b0;
            done        <= 1'b0;
        end else begin
            res_wr_en   <= srt_valid;
            res_wr_addr <= srt_tag[ADDR_W-1:0];
            res_wr_data <= picked;
            last_q      <= srt_valid && srt_tag[ADDR_W];
            done        <= last_q;
        end
    end

endmodule

// File: rtl/rank_filter3x3_chk.sv
// Protocol checker for rank_filter3x3, attached by bind.
// Assumes an always-ready result memory and a one-cycle source memory.
module rank_filter3x3_chk #(
    parameter int IMG_W = 200,
    parameter int IMG_H = 150,
    localparam int ADDR_W = $clog2(IMG_W * IMG_H),
    localparam int TOTAL  = IMG_W * IMG_H
) (
    input logic              clk,
    input logic              rst_n,
    input logic              src_rd_en,
    input logic [ADDR_W-1:0] src_rd_addr,
    input logic              res_wr_en,
    input logic [ADDR_W-1:0] res_wr_addr,
    input logic              done,
    input logic              busy,
    input logic [1:0]        mode_q
);

    assert_rd_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        src_rd_en |-> (src_rd_addr < ADDR_W'(TOTAL)));

    assert_rd_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        src_rd_en |=> (!src_rd_en || src_rd_addr == $past(src_rd_addr) + ADDR_W'(1)));

    assert_wr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        res_wr_en |-> (res_wr_addr < ADDR_W'(TOTAL)));

    assert_wr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        res_wr_en |=> (!res_wr_en || res_wr_addr == $past(res_wr_addr) + ADDR_W'(1)));

    assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mode_q));

    assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(res_wr_en) && $past(res_wr_addr) == ADDR_W'(TOTAL - 1)));

    assert_no_write_at_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !res_wr_en);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind rank_filter3x3 rank_filter3x3_chk #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_rd_en   (src_rd_en),
    .src_rd_addr (src_rd_addr),
    .res_wr_en   (res_wr_en),
    .res_wr_addr (res_wr_addr),
    .done        (done),
    .busy        (busy),
    .mode_q      (mode_q)
);

// File: tb/rank_filter3x3_bench.sv
// Scoreboard bench: the driver queues expected results per frame, the
// monitor compares each write and each source read as they appear.
module rank_filter3x3_bench;

    localparam int W      = 200;
    localparam int H      = 150;
    localparam int TOTAL  = W * H;
    localparam int ADDR_W = $clog2(TOTAL);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [1:0]        mode = 2'b00;
    logic              src_rd_en;
    logic [ADDR_W-1:0] src_rd_addr;
    logic [7:0]        src_rd_data = 8'h00;
    logic              res_wr_en;
    logic [ADDR_W-1:0] res_wr_addr;
    logic [7:0]        res_wr_data;
    logic              done;

    int n_checks = 0;
    int n_fails  = 0;
    int seed_g   = 0;
    int rd_expect = 0;
    bit done_seen = 1'b0;
    bit prev_last = 1'b0;
    bit finished  = 1'b0;

    typedef struct {
        int    addr;
        int    data;
        string req;
    } exp_t;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    rank_filter3x3 u_rank_filter3x3 (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .mode        (mode),
        .src_rd_en   (src_rd_en),
        .src_rd_addr (src_rd_addr),
        .src_rd_data (src_rd_data),
        .res_wr_en   (res_wr_en),
        .res_wr_addr (res_wr_addr),
        .res_wr_data (res_wr_data),
        .done        (done)
    );

    function automatic logic [7:0] pix_at(int y, int x, int s);
        int h;
        h = x * 37 + y * 11 + s * 5;
        if (h % 23 == 0) return 8'hFF;
        if (h % 29 == 0) return 8'h00;
        return 8'((x * 7 + y * 13 + s * 31) ^ (x * y));
    endfunction

    function automatic int ref_out(int y, int x, logic [1:0] m, int s);
        int v[9];
        int n, t, yy, xx;
        n = 0;
        for (int dy = -1; dy <= 1; dy++) begin
            for (int dx = -1; dx <= 1; dx++) begin
                yy = y + dy; xx = x + dx;
                if (yy < 0) yy = 0;
                if (yy > H - 1) yy = H - 1;
                if (xx < 0) xx = 0;
                if (xx > W - 1) xx = W - 1;
                v[n] = int'(pix_at(yy, xx, s));
                n++;
            end
        end
        for (int i = 0; i < 9; i++) begin
            for (int j = 0; j < 8 - i; j++) begin
                if (v[j] > v[j+1]) begin
                    t = v[j]; v[j] = v[j+1]; v[j+1] = t;
                end
            end
        end
        case (m)
            2'b01:   return v[0];
            2'b10:   return v[8];
            default: return v[4];
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int got, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    endtask

    // Source memory model: one-cycle registered function of the address.
    always @(posedge clk) begin
        if (src_rd_en) begin
            src_rd_data <= pix_at(int'(src_rd_addr) / W, int'(src_rd_addr) % W, seed_g);
        end
    end

    // Monitor: reads, writes and the done pulse, sampled on the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (src_rd_en) begin
                check(int'(src_rd_addr) == rd_expect, "R1", "read address",
                      int'(src_rd_addr), rd_expect);
                rd_expect++;
            end
            if (prev_last) begin
                check(done == 1'b1, "R9", "done after last write", int'(done), 1);
            end else if (done) begin
                check(1'b0, "R9", "unexpected done", 1, 0);
            end
            if (done) done_seen = 1'b1;
            if (res_wr_en) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R9", "write with no pending pixel", int'(res_wr_addr), -1);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(int'(res_wr_addr) == e.addr, "R2", "write address",
                          int'(res_wr_addr), e.addr);
                    check(int'(res_wr_data) == e.data, e.req, "pixel value",
                          int'(res_wr_data), e.data);
                end
            end
            prev_last = res_wr_en && (int'(res_wr_addr) == TOTAL - 1);
        end
    end

    // Driver: queue the expected frame, start it, wait for done.
    task automatic run_frame(input logic [1:0] m, input int s, input bit disturb);
        string mreq;
        int    waited;
        case (m)
            2'b00:   mreq = "R3";
            2'b01:   mreq = "R4";
            2'b10:   mreq = "R5";
            default: mreq = "R6";
        endcase
        seed_g = s;
        for (int y = 0; y < H; y++) begin
            for (int x = 0; x < W; x++) begin
                exp_t e;
                e.addr = y * W + x;
                e.data = ref_out(y, x, m, s);
                if (disturb) e.req = "R8";
                else if (y == 0 || y == H - 1 || x == 0 || x == W - 1) e.req = "R7";
                else e.req = mreq;
                sb_q.push_back(e);
            end
        end
        rd_expect = 0;
        done_seen = 1'b0;
        @(negedge clk);
        start = 1'b1;
        mode  = m;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            repeat (5000) @(negedge clk);
            mode  = ~m;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (!done_seen && waited < 40000) begin
            @(negedge clk);
            waited++;
        end
        check(done_seen, "R9", "done seen", int'(done_seen), 1);
        check(sb_q.size() == 0, "R2", "pending writes after done", sb_q.size(), 0);
        check(rd_expect == TOTAL, "R1", "source read count", rd_expect, TOTAL);
        sb_q.delete();
        // Quiet interval after done: the monitor flags any stray write.
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(src_rd_en == 1'b0, "R10", "read strobe in reset", int'(src_rd_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(res_wr_en == 1'b0, "R10", "write strobe after reset", int'(res_wr_en), 0);
        check(done == 1'b0, "R10", "done after reset", int'(done), 0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check(src_rd_en == 1'b0 && res_wr_en == 1'b0, "R10", "idle before start",
                  int'(src_rd_en) + int'(res_wr_en), 0);
        end
        run_frame(2'b00, 1, 1'b0);   // median
        run_frame(2'b01, 2, 1'b1);   // erosion, with a mid-frame start and mode change
        run_frame(2'b10, 3, 1'b0);   // dilation
        run_frame(2'b11, 4, 1'b0);   // alternate median code
        finish_run();
    end

    // Watchdog: a hung run ends as a failure and still prints the summary.
    initial begin
        repeat (195000) @(posedge clk);
        check(1'b0, "R9", "watchdog expired before completion", 0, 1);
        finish_run();
    end

endmodule